// File: doc/BRIEF.md
# Comparator Sampling Glitch Filter

This block conditions the one-bit outputs of a bank of analog voltage comparators before any control logic uses them. Each channel registers its asynchronous comparator bit on a common sample strobe, which removes metastable or racing edges from the downstream state machines. It then passes the sample through a small up/down saturating counter that rejects glitches and short transients and adds hysteresis.

The sample strobe is a one-clock pulse that a free-running divider produces every fourth system clock. A per-channel enable bit selects the filtered level or the raw synchronized sample. The block has plain level pins only. Comparator bits are levels rather than transfers, so there is no valid/ready handshake and no back-pressure. The output is a continuously valid level per channel.

Top module: `cmp_glitch_filter`

## Requirements
- R1: Each channel loads its comparator bit into a synchronizer register only on a sample strobe edge. With its filter bypassed, the channel output equals that register, so an input change made just after a strobe edge shows at the output exactly 4 clocks later and not before.
- R2: On each strobe edge the channel counter steps up by one when the synchronized sample is 1 and down by one when it is 0. A level that reverses partway therefore costs extra strobes before the output switches.
- R3: The 3-bit counter saturates. It holds at 7 while the sample stays 1 and at 0 while it stays 0, and never wraps. A level held far longer than 8 strobes still releases exactly 8 strobes after it ends.
- R4: The filtered level becomes 1 only when the counter reaches 7 and becomes 0 only when it reaches 0. At other counts it keeps its value. A one-sample glitch or an input that alternates on every sample never changes it.
- R5: The strobe is active once every 4 clocks. The first strobe edge is the 4th rising edge after reset is released. A clean step made just after a strobe edge reaches a filtered output 32 clocks (8 strobes) later.
- R6: filt_en[i]=1 selects the filtered level for channel i and filt_en[i]=0 selects the synchronized sample. Channels are independent of one another.
- R7: The counter and the filtered level keep tracking while a channel is bypassed. Setting its enable bit shows the tracked filtered level in the same cycle, with no restart.
- R8: A synchronous reset, active high, clears every synchronizer, counter, filtered level and the strobe divider. All outputs read 0 on the first clock after reset is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| comp_in | input | NCH | Raw comparator outputs, asynchronous |
| filt_en | input | NCH | Per-channel filter select, 1 = filtered |
| level_out | output | NCH | Conditioned channel levels |

## Verification
Every result follows a strobe, so the bench keeps its own count of clock edges from reset release and changes inputs only on falling edges that fall a whole number of sample periods after it. A bypassed output is due 4 clocks after a change, and a filtered step is due 32 clocks after. A step that reverses partway is due at an edge computed from the up/down count. The bench samples one edge before each due point and again at it, which catches an early or a late switch. Re-enable results are combinational and are read in the same cycle the enable bit changes.

// File: rtl/cmp_filt_pkg.sv
package cmp_filt_pkg;
  localparam int unsigned DEF_NCH      = 12;
  localparam int unsigned DEF_CNT_W    = 3;
  localparam int unsigned DEF_DIV_LOG2 = 2;
endpackage

// File: rtl/sample_strobe_gen.sv
module sample_strobe_gen #(
  parameter int unsigned DIV_LOG2 = cmp_filt_pkg::DEF_DIV_LOG2
) (
  input  logic clk,
  input  logic rst,
  output logic strobe
);
  localparam logic [DIV_LOG2-1:0] LAST = '1;

  logic [DIV_LOG2-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst) div_q <= '0;
    else     div_q <= div_q + 1'b1;
  end

  assign strobe = (div_q == LAST);

  // a strobe is never followed by another on the next clock
  assert_strobe_single_R5: assert property (@(posedge clk) disable iff (rst)
    strobe |=> !strobe);
  // no strobe on the first clock after reset
  assert_strobe_reset_R8: assert property (@(posedge clk)
    rst |=> !strobe);
endmodule

// File: rtl/chan_filter.sv
module chan_filter #(
  parameter int unsigned CNT_W = cmp_filt_pkg::DEF_CNT_W
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe,
  input  logic comp_raw,
  input  logic use_filter,
  output logic level
);
  localparam logic [CNT_W-1:0] TOP = '1;
  localparam logic [CNT_W-1:0] BOT = '0;

  logic             sync_q;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             flt_q;

  always_comb begin
    cnt_nxt = cnt_q;
    if (sync_q && cnt_q != TOP)       cnt_nxt = cnt_q + 1'b1;
    else if (!sync_q && cnt_q != BOT) cnt_nxt = cnt_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= 1'b0;
      cnt_q  <= BOT;
      flt_q  <= 1'b0;
    end else if (strobe) begin
      sync_q <= comp_raw;
      cnt_q  <= cnt_nxt;
      if (cnt_nxt == TOP)      flt_q <= 1'b1;
      else if (cnt_nxt == BOT) flt_q <= 1'b0;
    end
  end

  assign level = use_filter ? flt_q : sync_q;

  // state only moves on strobe edges
  assert_hold_off_strobe_R1: assert property (@(posedge clk) disable iff (rst)
    !strobe |=> ($stable(sync_q) && $stable(cnt_q) && $stable(flt_q)));
  // saturation at both ends
  assert_sat_top_R3: assert property (@(posedge clk) disable iff (rst)
    (strobe && sync_q && cnt_q == TOP) |=> cnt_q == TOP);
  assert_sat_bot_R3: assert property (@(posedge clk) disable iff (rst)
    (strobe && !sync_q && cnt_q == BOT) |=> cnt_q == BOT);
  // single step per strobe in the direction of the sample
  assert_step_up_R2: assert property (@(posedge clk) disable iff (rst)
    (strobe && sync_q && cnt_q != TOP) |=> cnt_q == $past(cnt_q) + 1'b1);
  // filtered level switches only at the extremes
  assert_rise_at_top_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(flt_q) |-> cnt_q == TOP);
  assert_fall_at_bot_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(flt_q) |-> cnt_q == BOT);
  // reset clears everything
  assert_reset_clear_R8: assert property (@(posedge clk)
    rst |=> (cnt_q == BOT && !flt_q && !sync_q));
endmodule

// File: rtl/cmp_glitch_filter.sv
module cmp_glitch_filter #(
  parameter int unsigned NCH      = cmp_filt_pkg::DEF_NCH,
  parameter int unsigned CNT_W    = cmp_filt_pkg::DEF_CNT_W,
  parameter int unsigned DIV_LOG2 = cmp_filt_pkg::DEF_DIV_LOG2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] comp_in,
  input  logic [NCH-1:0] filt_en,
  output logic [NCH-1:0] level_out
);
  logic strobe;

  sample_strobe_gen #(.DIV_LOG2(DIV_LOG2)) u_strobe (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe)
  );

  for (genvar gi = 0; gi < NCH; gi++) begin : g_chan
    chan_filter #(.CNT_W(CNT_W)) u_chan (
      .clk        (clk),
      .rst        (rst),
      .strobe     (strobe),
      .comp_raw   (comp_in[gi]),
      .use_filter (filt_en[gi]),
      .level      (level_out[gi])
    );
  end

  // outputs are low on the clock after reset
  assert_out_reset_R8: assert property (@(posedge clk)
    rst |=> level_out == '0);
endmodule

// File: tb/cmp_glitch_filter_bench.sv
`timescale 1ns/1ps
module cmp_glitch_filter_bench;
  localparam int NCH = 12;
  localparam time CLKP = 20ns;
  localparam int SP = 4; // clocks per sample period

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NCH-1:0] comp_in = '0;
  logic [NCH-1:0] filt_en = '1;
  logic [NCH-1:0] level_out;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #(CLKP/2) clk = ~clk;

  cmp_glitch_filter #(.NCH(NCH)) u_cmp_glitch_filter (
    .clk(clk), .rst(rst), .comp_in(comp_in), .filt_en(filt_en), .level_out(level_out)
  );

  task automatic chk(input string tag, input logic [NCH-1:0] got, input logic [NCH-1:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  // leaves the bench on a falling edge where edges-since-release = 0
  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    edges(2);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    comp_in = '1; filt_en = '0;
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    chk("R8 outputs low one clock after reset", level_out, '0);
    edges(1); rst = 1'b0;
    comp_in = '0; filt_en = '1;
  endtask

  task automatic t_bypass();
    do_reset();
    filt_en = '0;
    comp_in = 12'hA5C;
    edges(SP-1);
    chk("R1 bypass not before strobe", level_out, '0);
    edges(1);
    chk("R1 bypass after one strobe", level_out, 12'hA5C);
    comp_in = 12'h0F0;
    edges(SP-1);
    chk("R1 bypass holds between strobes", level_out, 12'hA5C);
    edges(1);
    chk("R1 bypass second sample", level_out, 12'h0F0);
  endtask

  task automatic t_step_rise();
    do_reset();
    filt_en = '1;
    comp_in = '1;
    edges(8*SP-1);
    chk("R5 filtered step not at 31 clocks", level_out, '0);
    edges(1);
    chk("R5 filtered step at 32 clocks", level_out, '1);
  endtask

  task automatic t_saturate_fall();
    do_reset();
    filt_en = '1;
    comp_in = '1;
    edges(20*SP);
    chk("R3 high held long", level_out, '1);
    comp_in = '0;
    edges(8*SP-1);
    chk("R3 no early release after saturation", level_out, '1);
    edges(1);
    chk("R3 release exactly 8 strobes after", level_out, '0);
  endtask

  task automatic t_glitch();
    do_reset();
    filt_en = '1;
    comp_in = '1;
    edges(SP);
    comp_in = '0;
    for (int k = 0; k < 12; k++) begin
      edges(SP);
      chk("R4 single-sample glitch blocked", level_out, '0);
    end
  endtask

  task automatic t_alternate();
    do_reset();
    filt_en = '1;
    for (int k = 0; k < 16; k++) begin
      comp_in = (k % 2 == 0) ? '1 : '0;
      edges(SP);
      chk("R4 alternating from low", level_out, '0);
    end
    comp_in = '1;
    edges(10*SP);
    chk("R4 settle high before alternating", level_out, '1);
    for (int k = 0; k < 16; k++) begin
      comp_in = (k % 2 == 0) ? '0 : '1;
      edges(SP);
      chk("R4 alternating from high", level_out, '1);
    end
  endtask

  // high at boundaries 0..5, low 6..7, high from 8: count peaks at 6, dips
  // to 4 and reaches 7 on strobe 12, i.e. edge 48
  task automatic t_updown();
    do_reset();
    filt_en = '1;
    comp_in = '1;
    edges(6*SP);
    comp_in = '0;
    edges(2*SP);
    comp_in = '1;
    edges(4*SP-1);
    chk("R2 reversal delays output (edge 47)", level_out, '0);
    edges(1);
    chk("R2 output after up/down count (edge 48)", level_out, '1);
  endtask

  task automatic t_independent();
    do_reset();
    filt_en = 12'h00F;
    comp_in = 12'h0F3;
    edges(SP);
    chk("R6 bypassed channels sample, filtered wait", level_out, 12'h0F0);
    edges(7*SP);
    chk("R6 mixed channels after 8 strobes", level_out, 12'h0F3);
  endtask

  task automatic t_reenable();
    do_reset();
    filt_en = '0;
    comp_in = '1;
    edges(10*SP);
    comp_in = '0;
    edges(2*SP);
    chk("R7 bypassed shows raw low", level_out, '0);
    filt_en = '1;
    #1;
    chk("R7 re-enable shows tracked level", level_out, '1);
    edges(6*SP-1);
    chk("R7 tracked count not yet zero", level_out, '1);
    edges(1);
    chk("R7 release continues from tracked count", level_out, '0);
  endtask

  task automatic t_midreset();
    do_reset();
    filt_en = '1;
    comp_in = '1;
    edges(8*SP);
    chk("R8 high before mid reset", level_out, '1);
    do_reset();
    chk("R8 cleared by mid reset", level_out, '0);
    edges(8*SP);
    chk("R8 refills after reset", level_out, '1);
  endtask

  initial begin
    edges(3);
    t_reset();
    t_bypass();
    t_step_rise();
    t_saturate_fall();
    t_glitch();
    t_alternate();
    t_updown();
    t_independent();
    t_reenable();
    t_midreset();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLKP*200000);
    if (!finished) begin
      finished = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule